// File: doc/BRIEF.md
# Byte FIFO and interrupt status unit

This unit sits between a simple synchronous register port and a serial bus engine. It holds two byte queues: one for bytes software wants sent, which the engine drains with a valid/ready handshake, and one for bytes the engine received, which software drains by reading a data register. Each queue has a programmable threshold and a self-clearing flush control.

The same unit gathers every interrupt source into a raw status word. Level sources (empty, full, threshold) follow the queue state every cycle. Event sources (overrun, transfer done, arbitration lost, bus error, target requests) are sticky until software clears them with a write-one-to-clear register. A mask register selects which raw bits reach the single interrupt output.

Top module: `xfer_fifo_irq`

## Requirements
- R1: Registers are picked by the 4-bit word index `reg_addr`: 0 control, 1 send data (write), 2 receive data (read), 3 send threshold, 4 receive threshold, 5 mask, 6 raw status, 7 masked status, 8 clear. After reset both queues are empty, both thresholds and the mask are 0, the raw status reads 0x33 (bits 0, 1, 4, 5), `irq` is 0 and `tx_valid` is 0.
- R2: Bytes written to index 1 leave on `tx_data` in write order; `tx_valid` is high while the send queue holds data and one byte is removed per cycle with `tx_valid` and `tx_ready` both high.
- R3: The send queue holds 16 bytes; a write to index 1 while it is full discards the byte and sets raw bit 3 (overrun), which stays set until cleared.
- R4: Each `rx_push` stores `rx_data` in the receive queue (16 bytes); a push while it is full is dropped. A read of index 2 returns the oldest byte and removes it; a read while it is empty returns 0 and changes nothing.
- R5: Raw bit 0 is send-queue empty, bit 1 is send level at or below the send threshold (index 3, 4 bits), bit 2 is send-queue full; all follow the level every cycle.
- R6: Raw bit 4 is receive-queue empty, bit 5 is receive level at or above the receive threshold (index 4, 4 bits), bit 6 is receive-queue full; all follow the level every cycle.
- R7: Writing 1 to control bit 7 (send) or bit 8 (receive) empties that queue; the bit reads 1 in the cycle after the write and 0 from the next cycle on, when the queue reads empty.
- R8: A high bit of `evt_set` at positions 16 to 20, 24, 25 or 28 sets the same raw bit, which stays set until cleared; other positions of `evt_set` have no effect. A set and a clear of the same bit in one cycle leave it set.
- R9: Writing index 8 clears each sticky raw bit written with 1 and leaves bits written with 0; level bits (0-2, 4-6) are unaffected because they follow the queues.
- R10: The mask keeps only the bits of 0x131F007F; masked status (index 7) is raw AND mask, `irq` is high when any masked bit is set, and bits 31:29 of raw, mask and masked status read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at index 2) |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| tx_valid | output | 1 | Send queue holds a byte |
| tx_data | output | 8 | Oldest byte of the send queue |
| tx_ready | input | 1 | Engine takes the byte on `tx_data` |
| rx_push | input | 1 | Engine delivers a received byte |
| rx_data | input | 8 | Received byte |
| evt_set | input | 29 | One-cycle event pulses from the engine, per raw bit |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the unit with its default parameters: 8-bit entries, 16-entry queues and a 32-bit register port. With that depth a seventeenth write or push is cheap to issue, so the overrun, dropped-push and full flags are all reached, and the 4-bit thresholds cover the whole level range. A scoreboard queue follows every accepted byte on both paths, so overflow discards and flushes show up as missing or extra bytes.

// File: rtl/xfi_pkg.sv
package xfi_pkg;
   // raw status width and bit groups
   localparam int          RAW_W       = 29;
   localparam logic [28:0] CLEARABLE   = 29'h131F007F;
   localparam logic [28:0] LEVEL_BITS  = 29'h0000_0077;
   localparam logic [28:0] EXT_EVENTS  = 29'h131F_0000;
   localparam logic [28:0] STICKY_BITS = CLEARABLE & ~LEVEL_BITS;

   // raw bit positions driven inside the unit
   localparam int B_TX_EMPTY = 0;
   localparam int B_TX_LOW   = 1;
   localparam int B_TX_FULL  = 2;
   localparam int B_TX_OVR   = 3;
   localparam int B_RX_EMPTY = 4;
   localparam int B_RX_HIGH  = 5;
   localparam int B_RX_FULL  = 6;

   // control bits
   localparam int C_TX_FLUSH = 7;
   localparam int C_RX_FLUSH = 8;

   // register word indices
   localparam logic [3:0] A_CTRL  = 4'd0;
   localparam logic [3:0] A_TXD   = 4'd1;
   localparam logic [3:0] A_RXD   = 4'd2;
   localparam logic [3:0] A_TXTHR = 4'd3;
   localparam logic [3:0] A_RXTHR = 4'd4;
   localparam logic [3:0] A_MASK  = 4'd5;
   localparam logic [3:0] A_RAW   = 4'd6;
   localparam logic [3:0] A_MSKD  = 4'd7;
   localparam logic [3:0] A_CLR   = 4'd8;
endpackage

// File: rtl/xfi_fifo.sv
module xfi_fifo #(
   parameter  int DW    = 8,
   parameter  int DEPTH = 16,
   localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int LW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] rdata,
   output logic [LW-1:0] level,
   output logic          empty,
   output logic          full
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("xfi_fifo: DEPTH must be at least 2");
   end
   if (DW < 1) begin : g_bad_width
      $error("xfi_fifo: DW must be at least 1");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic          do_push, do_pop;

   assign empty   = (level == '0);
   assign full    = (level == LW'(DEPTH));
   assign do_push = push && !full && !flush;
   assign do_pop  = pop && !empty && !flush;
   assign rdata   = mem[rd_ptr];

   // pointer wrap: free for powers of two, explicit compare otherwise
   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap
      assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         level <= level + LW'(do_push) - LW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end
endmodule

// File: rtl/xfi_irq.sv
module xfi_irq
   import xfi_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [RAW_W-1:0] level_bits,
   input  logic             ovr_evt,
   input  logic [RAW_W-1:0] evt_set,
   input  logic             clr_we,
   input  logic [RAW_W-1:0] clr_bits,
   input  logic             mask_we,
   input  logic [RAW_W-1:0] mask_bits,
   output logic [RAW_W-1:0] raw,
   output logic [RAW_W-1:0] masked,
   output logic [RAW_W-1:0] mask_q,
   output logic             irq
);
   logic [RAW_W-1:0] sticky_q, set_v, clr_v;

   always_comb begin
      set_v = evt_set & EXT_EVENTS;
      set_v[B_TX_OVR] = set_v[B_TX_OVR] | ovr_evt;
      clr_v = clr_we ? (clr_bits & STICKY_BITS) : '0;
   end

   // set wins over clear in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n) sticky_q <= '0;
      else        sticky_q <= (sticky_q & ~clr_v) | set_v;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       mask_q <= '0;
      else if (mask_we) mask_q <= mask_bits & CLEARABLE;
   end

   assign raw    = (sticky_q & STICKY_BITS) | (level_bits & LEVEL_BITS);
   assign masked = raw & mask_q;
   assign irq    = |masked;
endmodule

// File: rtl/xfer_fifo_irq.sv
module xfer_fifo_irq
   import xfi_pkg::*;
#(
   parameter  int DATA_W = 8,
   parameter  int DEPTH  = 16,
   parameter  int REG_W  = 32,
   localparam int TW     = $clog2(DEPTH),
   localparam int LW     = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [3:0]        reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   input  logic              tx_ready,
   input  logic              rx_push,
   input  logic [DATA_W-1:0] rx_data,
   input  logic [RAW_W-1:0]  evt_set,
   output logic              irq
);
   if (REG_W < RAW_W || REG_W < C_RX_FLUSH + 1) begin : g_bad_reg
      $error("xfer_fifo_irq: REG_W too narrow for status word");
   end
   if (DATA_W > REG_W) begin : g_bad_data
      $error("xfer_fifo_irq: DATA_W wider than register port");
   end
   if (TW > 4) begin : g_bad_thr
      $error("xfer_fifo_irq: threshold wider than 4 bits");
   end

   logic              wr_ctrl, wr_txd, wr_txthr, wr_rxthr, wr_mask, wr_clr, rd_rxd;
   logic              flush_tx, flush_rx;
   logic [TW-1:0]     tx_thr, rx_thr;
   logic [LW-1:0]     tx_level, rx_level;
   logic              tx_empty, tx_full, rx_empty, rx_full;
   logic [DATA_W-1:0] rx_head;
   logic              tx_ovr;
   logic [RAW_W-1:0]  level_bits, raw, masked, mask_q;

   assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
   assign wr_txd   = reg_wr && (reg_addr == A_TXD);
   assign wr_txthr = reg_wr && (reg_addr == A_TXTHR);
   assign wr_rxthr = reg_wr && (reg_addr == A_RXTHR);
   assign wr_mask  = reg_wr && (reg_addr == A_MASK);
   assign wr_clr   = reg_wr && (reg_addr == A_CLR);
   assign rd_rxd   = reg_rd && (reg_addr == A_RXD);

   // flush requests live for one cycle: the bit self-clears
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flush_tx <= 1'b0;
         flush_rx <= 1'b0;
      end else begin
         flush_tx <= wr_ctrl && reg_wdata[C_TX_FLUSH];
         flush_rx <= wr_ctrl && reg_wdata[C_RX_FLUSH];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_thr <= '0;
         rx_thr <= '0;
      end else begin
         if (wr_txthr) tx_thr <= reg_wdata[TW-1:0];
         if (wr_rxthr) rx_thr <= reg_wdata[TW-1:0];
      end
   end

   xfi_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_txq (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush_tx),
      .push  (wr_txd),
      .wdata (reg_wdata[DATA_W-1:0]),
      .pop   (tx_ready),
      .rdata (tx_data),
      .level (tx_level),
      .empty (tx_empty),
      .full  (tx_full)
   );

   xfi_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_rxq (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush_rx),
      .push  (rx_push),
      .wdata (rx_data),
      .pop   (rd_rxd),
      .rdata (rx_head),
      .level (rx_level),
      .empty (rx_empty),
      .full  (rx_full)
   );

   assign tx_valid = !tx_empty;
   assign tx_ovr   = wr_txd && tx_full && !flush_tx;

   always_comb begin
      level_bits             = '0;
      level_bits[B_TX_EMPTY] = tx_empty;
      level_bits[B_TX_LOW]   = (tx_level <= LW'(tx_thr));
      level_bits[B_TX_FULL]  = tx_full;
      level_bits[B_RX_EMPTY] = rx_empty;
      level_bits[B_RX_HIGH]  = (rx_level >= LW'(rx_thr));
      level_bits[B_RX_FULL]  = rx_full;
   end

   xfi_irq u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .level_bits (level_bits),
      .ovr_evt    (tx_ovr),
      .evt_set    (evt_set),
      .clr_we     (wr_clr),
      .clr_bits   (reg_wdata[RAW_W-1:0]),
      .mask_we    (wr_mask),
      .mask_bits  (reg_wdata[RAW_W-1:0]),
      .raw        (raw),
      .masked     (masked),
      .mask_q     (mask_q),
      .irq        (irq)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CTRL: begin
            reg_rdata[C_TX_FLUSH] = flush_tx;
            reg_rdata[C_RX_FLUSH] = flush_rx;
         end
         A_RXD:   if (!rx_empty) reg_rdata[DATA_W-1:0] = rx_head;
         A_TXTHR: reg_rdata[TW-1:0]    = tx_thr;
         A_RXTHR: reg_rdata[TW-1:0]    = rx_thr;
         A_MASK:  reg_rdata[RAW_W-1:0] = mask_q;
         A_RAW:   reg_rdata[RAW_W-1:0] = raw;
         A_MSKD:  reg_rdata[RAW_W-1:0] = masked;
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/xfer_fifo_irq_chk.sv
module xfer_fifo_irq_chk
   import xfi_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int REG_W = 32,
   parameter int LW    = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr,
   input logic             reg_rd,
   input logic [3:0]       reg_addr,
   input logic [REG_W-1:0] reg_wdata,
   input logic [REG_W-1:0] reg_rdata,
   input logic [LW-1:0]    tx_level,
   input logic [LW-1:0]    rx_level,
   input logic             flush_tx,
   input logic             flush_rx,
   input logic [RAW_W-1:0] raw,
   input logic [RAW_W-1:0] evt_set,
   input logic             irq
);
   // R3
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_level <= LW'(DEPTH));

   // R3
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (raw[B_TX_OVR] && !(reg_wr && reg_addr == A_CLR && reg_wdata[B_TX_OVR]))
      |=> raw[B_TX_OVR]);

   // R4
   rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_level == LW'(DEPTH) && !(reg_rd && reg_addr == A_RXD) && !flush_rx)
      |=> rx_level == LW'(DEPTH));

   // R7
   flush_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_CTRL && reg_wdata[C_TX_FLUSH]) |=> flush_tx);

   // R7
   flush_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_tx |=> (tx_level == '0));

   // R8
   evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_set[19] |=> raw[19]);

   // R10
   mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_MASK && reg_wdata == '0) |=> !irq);

   // R10
   upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == A_RAW || reg_addr == A_MASK || reg_addr == A_MSKD)
      |-> reg_rdata[REG_W-1:RAW_W] == '0);
endmodule

bind xfer_fifo_irq xfer_fifo_irq_chk #(.DEPTH(DEPTH), .REG_W(REG_W), .LW(LW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_rd    (reg_rd),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .tx_level  (tx_level),
   .rx_level  (rx_level),
   .flush_tx  (flush_tx),
   .flush_rx  (flush_rx),
   .raw       (raw),
   .evt_set   (evt_set),
   .irq       (irq)
);

// File: tb/xfer_fifo_irq_bench.sv
`timescale 1ns/1ps
module xfer_fifo_irq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        tx_valid;
   logic [7:0]  tx_data;
   logic        tx_ready = 1'b0;
   logic        rx_push = 1'b0;
   logic [7:0]  rx_data = '0;
   logic [28:0] evt_set = '0;
   logic        irq;

   int checks = 0;
   int errors = 0;
   logic [7:0] tx_q[$];
   logic [7:0] rx_q[$];
   logic [31:0] d;

   always #2.5 clk = ~clk;

   xfer_fifo_irq u_xfer_fifo_irq (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
      .rx_push(rx_push), .rx_data(rx_data), .evt_set(evt_set), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // all tasks start and end on a falling edge
   task automatic wr(input logic [3:0] a, input logic [31:0] v);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] v);
      reg_rd = 1'b1; reg_addr = a;
      #1 v = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   // driver: records accepted send bytes in the scoreboard
   task automatic send(input logic [7:0] b);
      if (tx_q.size() < 16) tx_q.push_back(b);
      wr(4'd1, {24'h0, b});
   endtask

   task automatic push(input logic [7:0] b);
      if (rx_q.size() < 16) rx_q.push_back(b);
      rx_push = 1'b1; rx_data = b;
      @(negedge clk);
      rx_push = 1'b0;
   endtask

   task automatic pull(input string tag);
      logic [31:0] v;
      logic [31:0] exp;
      exp = (rx_q.size() > 0) ? {24'h0, rx_q.pop_front()} : 32'h0;
      rd(4'd2, v);
      chk(tag, v, exp);
   endtask

   task automatic drain();
      tx_ready = 1'b1;
      repeat (20) @(negedge clk);
      tx_ready = 1'b0;
      chk("R2 scoreboard empty after drain", tx_q.size(), 0);
   endtask

   // monitor: compares each byte the engine takes with the scoreboard
   always begin
      @(negedge clk);
      #1;
      if (rst_n && tx_valid && tx_ready) begin
         if (tx_q.size() == 0) chk("R2/R3 unexpected send byte", {24'h0, tx_data}, 32'hxxxx_xxxx);
         else chk("R2 send order", {24'h0, tx_data}, {24'h0, tx_q.pop_front()});
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(4'd6, d); chk("R1 raw after reset", d, 32'h33);
      rd(4'd5, d); chk("R1 mask after reset", d, 32'h0);
      chk("R1 irq after reset", {31'h0, irq}, 32'h0);
      chk("R1 tx_valid after reset", {31'h0, tx_valid}, 32'h0);

      // R2 / R5 order and send-level flags
      send(8'hA1); send(8'hB2); send(8'hC3);
      rd(4'd6, d); chk("R5 raw with 3 queued, thr 0", d, 32'h30);
      wr(4'd3, 32'd3);
      rd(4'd6, d); chk("R5 raw with 3 queued, thr 3", d, 32'h32);
      drain();

      // R3 full and overrun
      for (int i = 0; i < 16; i++) send(8'(8'h40 + i));
      rd(4'd6, d); chk("R5 raw send full", d, 32'h34);
      send(8'hEE);
      rd(4'd6, d); chk("R3 overrun flag", d, 32'h3C);
      drain();
      rd(4'd6, d); chk("R3 overrun sticky after drain", d, 32'h3B);

      // R9 clear all
      wr(4'd8, 32'hFFFF_FFFF);
      rd(4'd6, d); chk("R9 clear all, level bits kept", d, 32'h33);

      // R6 / R4 receive path
      wr(4'd4, 32'd2);
      rd(4'd6, d); chk("R6 raw rx thr 2 empty", d, 32'h13);
      push(8'h11); push(8'h22);
      rd(4'd6, d); chk("R6 raw rx at threshold", d, 32'h23);
      pull("R4 rx first"); pull("R4 rx second");
      pull("R4 rx empty read gives 0");
      rd(4'd6, d); chk("R4 empty read leaves state", d, 32'h13);
      for (int i = 0; i < 17; i++) push(8'(8'h80 + i));
      rd(4'd6, d); chk("R6 raw rx full", d, 32'h63);
      for (int i = 0; i < 16; i++) pull("R4 rx fill order, 17th dropped");
      rd(4'd6, d); chk("R4 rx empty after 16 reads", d, 32'h13);

      // R7 flush
      for (int i = 0; i < 5; i++) send(8'(8'h60 + i));
      rd(4'd6, d); chk("R5 raw 5 queued", d, 32'h10);
      wr(4'd0, 32'h80);
      rd(4'd0, d); chk("R7 send flush reads 1", d, 32'h80);
      rd(4'd0, d); chk("R7 send flush self-clears", d, 32'h0);
      tx_q.delete();
      rd(4'd6, d); chk("R7 send queue empty after flush", d, 32'h13);
      send(8'h5A);
      drain();
      push(8'h01); push(8'h02); push(8'h03);
      wr(4'd0, 32'h100);
      rd(4'd0, d); chk("R7 recv flush reads 1", d, 32'h100);
      rd(4'd0, d); chk("R7 recv flush self-clears", d, 32'h0);
      rx_q.delete();
      rd(4'd6, d); chk("R7 recv queue empty after flush", d, 32'h13);
      pull("R7 recv read after flush gives 0");

      // R8 events
      evt_set = 29'((1 << 19) | (1 << 24) | (1 << 10) | (1 << 3));
      @(negedge clk);
      evt_set = '0;
      rd(4'd6, d); chk("R8 events latched, others ignored", d, 32'h0108_0013);
      @(negedge clk); @(negedge clk);
      rd(4'd6, d); chk("R8 events stay set", d, 32'h0108_0013);

      // R9 clear behaviour
      wr(4'd8, 32'h0008_0000);
      rd(4'd6, d); chk("R9 clear one bit", d, 32'h0100_0013);
      wr(4'd8, 32'h0);
      rd(4'd6, d); chk("R9 zero write no effect", d, 32'h0100_0013);
      wr(4'd8, 32'h1);
      rd(4'd6, d); chk("R9 clear of level bit no effect", d, 32'h0100_0013);
      evt_set = 29'(1 << 25);
      wr(4'd8, 32'h0200_0000);
      evt_set = '0;
      rd(4'd6, d); chk("R8 set wins over clear", d, 32'h0300_0013);

      // R10 mask and interrupt
      wr(4'd5, 32'hFFFF_FFFF);
      rd(4'd5, d); chk("R10 mask keeps implemented bits", d, 32'h131F_007F);
      rd(4'd7, d); chk("R10 masked status", d, 32'h0300_0013);
      #1 chk("R10 irq with full mask", {31'h0, irq}, 32'h1);
      @(negedge clk);
      wr(4'd5, 32'h0100_0000);
      #1 chk("R10 irq from bit 24", {31'h0, irq}, 32'h1);
      @(negedge clk);
      wr(4'd8, 32'h0100_0000);
      #1 chk("R10 irq drops after clear", {31'h0, irq}, 32'h0);
      @(negedge clk);
      wr(4'd5, 32'h10);
      #1 chk("R10 irq from level bit", {31'h0, irq}, 32'h1);
      @(negedge clk);
      wr(4'd5, 32'h0);
      #1 chk("R10 irq with mask 0", {31'h0, irq}, 32'h0);
      @(negedge clk);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule